// File: doc/BRIEF.md
# Multidrop UART Address-Filtering Receiver

This block is the receive side of a serial port on a shared multidrop line, where one master talks to several slaves. It takes an RX line oversampled sixteen times per bit, recovers each character, and marks every frame as an address frame or a data frame from one extra bit that follows the data bits. A slave stays in address-only mode while `mp_en` is high. In that mode, data frames meant for other slaves vanish without a trace. Once software has matched its own address, it drops `mp_en` and every frame is taken until it raises the mode again.

Accepted frames go into a four-entry receive FIFO. The head entry is shown at the outputs together with its type bit and a framing-error flag, and `rx_ready` serves as the receive-complete flag. `rts_n` tells the far transmitter to pause once the FIFO is full. A frame that is accepted while no slot is free is lost and raises a sticky overrun flag. The block takes its 16x sampling strobe from outside and has no transmitter or parity logic.

Top module: `mdrop_rx`

## Requirements
- R1: `char_sel` picks the data width: 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits; 7 gives 9-bit characters (8 data bits plus type); 4 to 6 act as 8 data bits. Data arrives least significant bit first, and `rx_data` bits above the width read 0.
- R2: The bit right after the data bits is the type bit (the ninth bit in 9-bit mode, the first stop bit otherwise); `rx_kind` = 1 marks an address frame and 0 a data frame.
- R3: While `mp_en` is 1, a data frame is discarded: no FIFO entry, no change to `rx_ready`, `rts_n` or `overrun`, even with the FIFO full.
- R4: While `mp_en` is 1, an address frame is stored like any other and raises `rx_ready`.
- R5: While `mp_en` is 0, every frame is stored regardless of its type bit.
- R6: A 0 sampled in the final stop bit sets `rx_ferr` on that entry; the type-carrying first stop bit of 5- to 8-bit modes is never checked for framing.
- R7: A falling edge starts a frame only if the line still votes low at the middle of the start bit; a low pulse of a few samples produces no frame.
- R8: The FIFO holds 4 entries and releases them in arrival order; `rx_ready` is 1 while it is not empty and a one-cycle `pop` removes the head.
- R9: `rts_n` is 0 while the FIFO holds fewer than 4 entries and 1 while it holds 4.
- R10: An accepted frame that finds the FIFO full is dropped and sets `overrun`, which stays 1 until `ovr_clr`; a new overrun in the same cycle as `ovr_clr` wins.
- R11: After reset `rx_ready`, `rts_n` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Sampling strobe, 16 per bit period |
| rx_in | input | 1 | Serial receive line, idle high |
| char_sel | input | 3 | Character size code |
| mp_en | input | 1 | Address-only (multiprocessor) mode |
| pop | input | 1 | Remove the head FIFO entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rx_ready | output | 1 | Receive complete: FIFO not empty |
| rx_data | output | 8 | Head entry data |
| rx_kind | output | 1 | Head entry type, 1 = address |
| rx_ferr | output | 1 | Head entry framing error |
| rts_n | output | 1 | Flow control, high = FIFO full |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach from the ports is a data frame that arrives in address-only mode while the FIFO is already full. Only there does discarding it differ from overrunning on it. The stimulus fills all four slots with mode off and checks that `rts_n` has risen. It then turns the mode on and sends a data frame, which must leave `overrun` low and the stored entries intact. An address frame sent next must raise `overrun`. A short low pulse on the idle line is also driven, so that start-bit rejection is seen without a frame reaching the FIFO.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

    localparam int OSR      = 16;                 // samples per bit
    localparam int PH_W     = $clog2(OSR);
    localparam int VOTE_PH  = OSR / 2 + 1;        // vote over samples 7,8,9
    localparam int DATA_W   = 8;
    localparam int MIN_BITS = 5;
    localparam int CNT_W    = $clog2(DATA_W + 2); // data + type + stop index
    localparam int IDX_W    = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic              kind;   // 1 = address frame
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic logic [CNT_W-1:0] data_bits(input logic [2:0] sel);
        if (sel < 3'd4)
            return CNT_W'(sel) + CNT_W'(MIN_BITS);
        else
            return CNT_W'(DATA_W);
    endfunction

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/mdrop_rx_sampler.sv
module mdrop_rx_sampler
    import mdrop_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx_in,
    output logic rx_fall,
    output logic vote
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             hist_q;
    logic                   line_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rx_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
            end
        end
    endgenerate

    assign line_s = sync_q[SYNC_STAGES-1];

    // sample history, newest in bit 0
    always_ff @(posedge clk) begin
        if (rst)       hist_q <= 3'b111;
        else if (tick) hist_q <= {hist_q[1:0], line_s};
    end

    assign rx_fall = tick && hist_q[0] && !line_s;
    assign vote    = maj3(hist_q);

endmodule

// File: rtl/mdrop_rx_deframe.sv
module mdrop_rx_deframe
    import mdrop_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_fall,
    input  logic       vote,
    input  logic [2:0] char_sel,
    output logic       done,
    output rx_entry_t  frame
);

    rx_state_e        st_q;
    logic [PH_W-1:0]  ph_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] nbits_q;
    logic             at_vote;

    assign at_vote = tick && (ph_q == PH_W'(VOTE_PH));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ph_q    <= '0;
            idx_q   <= '0;
            nbits_q <= CNT_W'(DATA_W);
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) ph_q <= ph_q + 1'b1;
            unique case (st_q)
                ST_IDLE: begin
                    if (rx_fall) begin
                        st_q <= ST_START;
                        ph_q <= '0;
                    end
                end
                ST_START: begin
                    if (at_vote) begin
                        if (vote) begin
                            st_q <= ST_IDLE;        // false start
                        end else begin
                            st_q       <= ST_BITS;
                            idx_q      <= '0;
                            nbits_q    <= data_bits(char_sel);
                            frame.data <= '0;
                        end
                    end
                end
                ST_BITS: begin
                    if (at_vote) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q < nbits_q) begin
                            frame.data[idx_q[IDX_W-1:0]] <= vote;
                        end else if (idx_q == nbits_q) begin
                            frame.kind <= vote;     // type bit, never framing-checked
                        end else begin
                            frame.ferr <= !vote;    // final stop bit
                            done       <= 1'b1;
                            st_q       <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
    parameter  int DEPTH = 4,
    parameter  int W     = 10,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [LVL_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == LVL_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && wr_q == PTR_W'(g)) mem_q[g] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= step(wr_q);
            if (do_pop)  rd_q <= step(rd_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout  = mem_q[rd_q];
    assign level = cnt_q;

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
    import mdrop_rx_pkg::*;
#(
    parameter  int DEPTH       = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int LVL_W       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic [2:0]        char_sel,
    input  logic              mp_en,
    input  logic              pop,
    input  logic              ovr_clr,
    output logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_kind,
    output logic              rx_ferr,
    output logic              rts_n,
    output logic              overrun
);

    logic             rx_fall, vote;
    logic             frm_done;
    rx_entry_t        frm;
    rx_entry_t        head;
    logic             accept, fifo_push;
    logic             fifo_empty, fifo_full;
    logic [LVL_W-1:0] fifo_level;
    logic             ovr_q;

    mdrop_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .rx_in   (rx_in),
        .rx_fall (rx_fall),
        .vote    (vote)
    );

    mdrop_rx_deframe u_dfr (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .rx_fall  (rx_fall),
        .vote     (vote),
        .char_sel (char_sel),
        .done     (frm_done),
        .frame    (frm)
    );

    // address filter: data frames vanish in address-only mode
    assign accept    = frm_done && (frm.kind || !mp_en);
    assign fifo_push = accept && !fifo_full;

    mdrop_rx_fifo #(.DEPTH(DEPTH), .W($bits(rx_entry_t))) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .din   (frm),
        .pop   (pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .level (fifo_level)
    );

    always_ff @(posedge clk) begin
        if (rst)                       ovr_q <= 1'b0;
        else if (accept && fifo_full)  ovr_q <= 1'b1;
        else if (ovr_clr)              ovr_q <= 1'b0;
    end

    assign rx_ready = !fifo_empty;
    assign rx_data  = head.data;
    assign rx_kind  = head.kind;
    assign rx_ferr  = head.ferr;
    assign rts_n    = fifo_full;
    assign overrun  = ovr_q;

endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
    parameter  int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             mp_en,
    input logic             pop,
    input logic             ovr_clr,
    input logic             frm_done,
    input logic             frm_kind,
    input logic             push,
    input logic [LVL_W-1:0] level,
    input logic             rts_n,
    input logic             overrun
);

    // R3: a data frame in address-only mode leaves the FIFO level alone
    p_data_level_r3: assert property (@(posedge clk) disable iff (rst)
        frm_done && mp_en && !frm_kind && !pop |=> $stable(level));

    // R3: ... and never touches the overrun flag
    p_data_ovr_r3: assert property (@(posedge clk) disable iff (rst)
        frm_done && mp_en && !frm_kind && !ovr_clr |=> $stable(overrun));

    // R4: an address frame with room is stored
    p_addr_take_r4: assert property (@(posedge clk) disable iff (rst)
        frm_done && frm_kind && level < LVL_W'(DEPTH) && !pop
        |=> level == $past(level) + LVL_W'(1));

    // R5: with mode off any frame with room is stored
    p_all_take_r5: assert property (@(posedge clk) disable iff (rst)
        frm_done && !mp_en && level < LVL_W'(DEPTH) && !pop
        |=> level == $past(level) + LVL_W'(1));

    // R8: occupancy never exceeds capacity
    p_level_cap_r8: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    // R9: flow control only rises after a store
    p_rts_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_n) |-> $past(push));

    // R10: overrun is sticky until cleared
    p_ovr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        overrun && !ovr_clr |=> overrun);

    // R10: overrun only arises from a frame meeting a full FIFO
    p_ovr_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(rts_n) && $past(frm_done));

endmodule

bind mdrop_rx mdrop_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mp_en    (mp_en),
    .pop      (pop),
    .ovr_clr  (ovr_clr),
    .frm_done (frm_done),
    .frm_kind (frm.kind),
    .push     (fifo_push),
    .level    (fifo_level),
    .rts_n    (rts_n),
    .overrun  (overrun)
);

// File: tb/mdrop_rx_test.sv
module mdrop_rx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic [2:0] char_sel = 3'd3;
    logic       mp_en = 1'b0;
    logic       pop = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       rx_ready, rx_kind, rx_ferr, rts_n, overrun;
    logic [7:0] rx_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_run = 0;

    always #5 clk = ~clk;

    mdrop_rx uut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
        .char_sel(char_sel), .mp_en(mp_en), .pop(pop), .ovr_clr(ovr_clr),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_kind(rx_kind),
        .rx_ferr(rx_ferr), .rts_n(rts_n), .overrun(overrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        @(negedge clk) rx_in = v;
        repeat (15) @(negedge clk);
    endtask

    task automatic send(input int nd, input logic [7:0] d, input logic kind, input logic stop);
        line_bit(1'b0);
        for (int i = 0; i < nd; i++) line_bit(d[i]);
        line_bit(kind);
        line_bit(stop);
        @(negedge clk) rx_in = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic take(input string tag, input logic [7:0] d, input logic kind, input logic ferr);
        chk({tag, " ready"}, rx_ready, 1);
        chk({tag, " data"},  rx_data,  d);
        chk({tag, " kind"},  rx_kind,  kind);
        chk({tag, " ferr"},  rx_ferr,  ferr);
        pop = 1'b1;
        @(negedge clk) pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 rx_ready", rx_ready, 0);
        chk("R11 rts_n",    rts_n,    0);
        chk("R11 overrun",  overrun,  0);
    endtask

    task automatic t_sizes;
        mp_en = 1'b0;
        char_sel = 3'd0; send(5, 8'hF5, 1'b1, 1'b1); take("R1 5-bit", 8'h15, 1'b1, 1'b0);
        char_sel = 3'd1; send(6, 8'h2A, 1'b0, 1'b1); take("R1 6-bit", 8'h2A, 1'b0, 1'b0);
        char_sel = 3'd2; send(7, 8'h55, 1'b1, 1'b1); take("R1 7-bit", 8'h55, 1'b1, 1'b0);
        char_sel = 3'd3; send(8, 8'hA5, 1'b0, 1'b1); take("R2 8-bit", 8'hA5, 1'b0, 1'b0);
        char_sel = 3'd7; send(8, 8'h3C, 1'b1, 1'b1); take("R2 9-bit", 8'h3C, 1'b1, 1'b0);
        char_sel = 3'd5; send(8, 8'hC6, 1'b0, 1'b1); take("R1 code5", 8'hC6, 1'b0, 1'b0);
        char_sel = 3'd3;
    endtask

    task automatic t_filter;
        mp_en = 1'b1;
        send(8, 8'h33, 1'b0, 1'b1);
        chk("R3 data dropped", rx_ready, 0);
        send(8, 8'h42, 1'b1, 1'b1);
        take("R4 address", 8'h42, 1'b1, 1'b0);
        mp_en = 1'b0;
        send(8, 8'h5A, 1'b0, 1'b1);
        take("R5 data open", 8'h5A, 1'b0, 1'b0);
    endtask

    task automatic t_framing;
        char_sel = 3'd3;
        send(8, 8'hC3, 1'b1, 1'b0); take("R6 bad stop",    8'hC3, 1'b1, 1'b1);
        send(8, 8'h3C, 1'b0, 1'b1); take("R6 type stop 0", 8'h3C, 1'b0, 1'b0);
        char_sel = 3'd7;
        send(8, 8'h81, 1'b1, 1'b0); take("R6 9-bit stop",  8'h81, 1'b1, 1'b1);
        char_sel = 3'd3;
    endtask

    task automatic t_glitch;
        @(negedge clk) rx_in = 1'b0;
        repeat (3) @(negedge clk);
        rx_in = 1'b1;
        repeat (200) @(negedge clk);
        chk("R7 glitch ignored", rx_ready, 0);
        send(8, 8'h6E, 1'b1, 1'b1);
        take("R7 after glitch", 8'h6E, 1'b1, 1'b0);
    endtask

    task automatic t_fifo_ovr;
        mp_en = 1'b0;
        for (int i = 0; i < 3; i++) send(8, 8'h11 + 8'(i), 1'b0, 1'b1);
        chk("R9 rts 3 held", rts_n, 0);
        send(8, 8'h14, 1'b0, 1'b1);
        chk("R9 rts full", rts_n, 1);
        mp_en = 1'b1;
        send(8, 8'h77, 1'b0, 1'b1);
        chk("R3 full data no ovr", overrun, 0);
        chk("R3 full data rts", rts_n, 1);
        send(8, 8'h99, 1'b1, 1'b1);
        chk("R10 overrun set", overrun, 1);
        mp_en = 1'b0;
        for (int i = 0; i < 4; i++) take("R8 order", 8'h11 + 8'(i), 1'b0, 1'b0);
        chk("R8 drained", rx_ready, 0);
        chk("R9 rts released", rts_n, 0);
        chk("R10 overrun sticky", overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk) ovr_clr = 1'b0;
        chk("R10 overrun cleared", overrun, 0);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_sizes;
        t_filter;
        t_framing;
        t_glitch;
        t_fifo_ovr;
        done_run = 1;
        finish_run;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run;
        end
    end

endmodule